// File: doc/BRIEF.md
# Hidden Cipher Key Store

This block keeps the keys that a block cipher engine uses. Software can write keys into it and can never read them back. It holds four software-loaded keys and one fuse-derived key, and each key is 128 bits wide to suit an AES-128 datapath.

Software loads a key through a small register port. It first writes a select register that names the target slot and the starting subword. It then writes 32-bit words to a data register. After each word the subword pointer steps forward by itself, so a whole key goes in as one select write followed by four data writes. Reading the data register always returns zero, so stored key material never appears on the register bus. Software can still see which slots hold a complete key through a status register.

After reset, a one-cycle strobe on a parallel 128-bit port captures the fuse key into its own slot. Only the first strobe after reset is taken. The cipher engine reads keys through a separate port: it drives a slot number and receives the selected key one cycle later. The returned key is all zeros when the slot has not been completely loaded or the slot number does not exist.

Top module: `cipher_key_vault`

## Requirements
- R1: After reset, all slot-valid flags are clear, the slot index and subword pointer are 0, and both `reg_rdata` and `key_out` are zero.
- R2: A write to address 0 sets the slot index from `reg_wdata[2:0]` and the subword pointer from `reg_wdata[9:8]`. A read of address 0 returns them in those same bit positions, with every other bit zero.
- R3: A write to address 1 stores the word into the subword of the selected slot that the pointer names, where subword 0 holds key bits [31:0]. The pointer then advances by one and wraps from 3 to 0. The slot index does not change.
- R4: A read of address 1 returns zero whatever keys are stored. A read of address 3 also returns zero. Register read data appears in the cycle after `reg_rd_en` and is zero when no read was issued.
- R5: A slot's valid flag is set when subword 3 of that slot is written. It stays set until reset. A read of address 2 returns the flags in bits [4:0], with bit n for slot n and bit 4 for the fuse slot.
- R6: Data writes while the slot index is 4 to 7 change no stored key and no valid flag. The pointer still advances.
- R7: The first `fuse_key_stb` pulse after reset captures `fuse_key` into slot 4 and sets the valid flag of slot 4. Later pulses are ignored until the next reset.
- R8: `key_out` shows, one cycle after `key_sel` is sampled, the key of the selected slot. It is zero when that slot's valid flag is clear or when `key_sel` is 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 select, 1 data, 2 status, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| fuse_key_stb | input | 1 | One-cycle strobe marking a valid fuse key |
| fuse_key | input | 128 | Fuse-derived key |
| key_sel | input | 3 | Slot number requested by the cipher engine |
| key_out | output | 128 | Selected key, one cycle after `key_sel` |

## Verification
Each result is due exactly one clock edge after its stimulus. A select write, a data write or a fuse strobe changes state at the edge that samples it. A register read shows up on `reg_rdata` after the next edge, and a key lookup shows up on `key_out` after the edge that samples `key_sel`. The bench drives every stimulus at a falling edge and holds it for one full cycle. It then compares the outputs at the following falling edge against a reference model that it updates in program order. This places each comparison half a cycle after the single register that produces the result.

// File: rtl/ckv_pkg.sv
// Shared constants and register address encoding for the hidden cipher key store.
// Assumes one word-wide register port and a fixed register address map.
package ckv_pkg;
    localparam int WORD_W    = 32;
    localparam int KEY_WORDS = 4;
    localparam int KEY_W     = WORD_W * KEY_WORDS;
    localparam int SW_SLOTS  = 4;
    localparam int ALL_SLOTS = SW_SLOTS + 1;
    localparam int FUSE_SLOT = SW_SLOTS;
    localparam int SEL_W     = 3;
    localparam int PTR_W     = $clog2(KEY_WORDS);
    localparam int PTR_LSB   = 8;

    typedef enum logic [1:0] {
        REG_SELECT = 2'd0,
        REG_DATA   = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ckv_regif.sv
// Register front end: it holds the slot index and the auto-advancing subword pointer,
// turns data writes into key-word write requests, and builds the read data.
// Assumes single-cycle strobes. Key material is never routed to the read data.
module ckv_regif
    import ckv_pkg::*;
#(
    parameter int DW    = WORD_W,
    parameter int SW    = SEL_W,
    parameter int PW    = PTR_W,
    parameter int NSW   = SW_SLOTS,
    parameter int NALL  = ALL_SLOTS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NALL-1:0] valid_flags,
    output logic [DW-1:0]   rdata,
    output logic            kw_en,
    output logic [SW-1:0]   kw_slot,
    output logic [PW-1:0]   kw_word,
    output logic [DW-1:0]   kw_data,
    output logic [SW-1:0]   cur_slot,
    output logic [PW-1:0]   cur_ptr
);
    localparam logic [SW-1:0] FIRST_HIDDEN = SW'(NSW);

    logic [SW-1:0] slot_q;
    logic [PW-1:0] ptr_q;
    logic          sel_wr;
    logic          data_wr;
    logic [DW-1:0] select_view;
    logic [DW-1:0] status_view;

    assign sel_wr  = wr_en && (addr == REG_SELECT);
    assign data_wr = wr_en && (addr == REG_DATA);

    // Slot index and subword pointer: loaded by a select write, stepped by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            ptr_q  <= '0;
        end else if (sel_wr) begin
            slot_q <= wdata[SW-1:0];
            ptr_q  <= wdata[PTR_LSB +: PW];
        end else if (data_wr) begin
            ptr_q  <= ptr_q + PW'(1);
        end
    end

    // Key-word write request, only for slots that software may fill.
    always_comb begin
        kw_en   = data_wr && (slot_q < FIRST_HIDDEN);
        kw_slot = slot_q;
        kw_word = ptr_q;
        kw_data = wdata;
    end

    // Readable views: select register and valid flags; nothing from the key storage.
    always_comb begin
        select_view = '0;
        select_view[SW-1:0] = slot_q;
        select_view[PTR_LSB +: PW] = ptr_q;
        status_view = '0;
        status_view[NALL-1:0] = valid_flags;
    end

    // Registered read data, zero for the data and spare addresses and when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                REG_SELECT: rdata <= select_view;
                REG_STATUS: rdata <= status_view;
                default:    rdata <= '0;
            endcase
        end else begin
            rdata <= '0;
        end
    end

    assign cur_slot = slot_q;
    assign cur_ptr  = ptr_q;
endmodule

// File: rtl/ckv_slot_store.sv
// Key storage: software slots written one subword at a time, plus one fuse slot
// captured by the first strobe after reset. Each slot has a sticky valid flag.
// Assumes the write request has already been filtered to software slots.
module ckv_slot_store
    import ckv_pkg::*;
#(
    parameter int DW   = WORD_W,
    parameter int NW   = KEY_WORDS,
    parameter int SW   = SEL_W,
    parameter int PW   = PTR_W,
    parameter int NSW  = SW_SLOTS,
    localparam int KW   = DW * NW,
    localparam int NALL = NSW + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kw_en,
    input  logic [SW-1:0]            kw_slot,
    input  logic [PW-1:0]            kw_word,
    input  logic [DW-1:0]            kw_data,
    input  logic                     fuse_stb,
    input  logic [KW-1:0]            fuse_key,
    output logic [NALL-1:0][KW-1:0]  slot_keys,
    output logic [NALL-1:0]          slot_valid,
    output logic                     fuse_taken
);
    localparam logic [PW-1:0] LAST_WORD = PW'(NW - 1);

    for (genvar s = 0; s < NSW; s++) begin : g_sw_slot
        localparam logic [SW-1:0] MY_SLOT = SW'(s);
        logic [KW-1:0] key_q;
        logic          val_q;

        // One software slot: store the addressed subword and mark valid on the last one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q <= '0;
                val_q <= 1'b0;
            end else if (kw_en && (kw_slot == MY_SLOT)) begin
                key_q[kw_word*DW +: DW] <= kw_data;
                if (kw_word == LAST_WORD) begin
                    val_q <= 1'b1;
                end
            end
        end

        assign slot_keys[s]  = key_q;
        assign slot_valid[s] = val_q;
    end

    logic [KW-1:0] fuse_q;
    logic          taken_q;

    // Fuse slot: take the first strobe after reset and ignore the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q  <= '0;
            taken_q <= 1'b0;
        end else if (fuse_stb && !taken_q) begin
            fuse_q  <= fuse_key;
            taken_q <= 1'b1;
        end
    end

    assign slot_keys[NSW]  = fuse_q;
    assign slot_valid[NSW] = taken_q;
    assign fuse_taken      = taken_q;
endmodule

// File: rtl/ckv_read_port.sv
// Cipher-side lookup: registered select of one slot's key, forced to zero
// for slots that are not valid and for slot numbers that do not exist.
module ckv_read_port
    import ckv_pkg::*;
#(
    parameter int KW   = KEY_W,
    parameter int SW   = SEL_W,
    parameter int NALL = ALL_SLOTS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SW-1:0]           key_sel,
    input  logic [NALL-1:0][KW-1:0] slot_keys,
    input  logic [NALL-1:0]         slot_valid,
    output logic [KW-1:0]           key_out
);
    logic [KW-1:0] picked;

    // Gate each valid slot onto the output when its number matches.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NALL; i++) begin
            if ((key_sel == SW'(i)) && slot_valid[i]) begin
                picked = slot_keys[i];
            end
        end
    end

    // Register the picked key for the cipher engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_out <= '0;
        end else begin
            key_out <= picked;
        end
    end
endmodule

// File: rtl/cipher_key_vault.sv
// Top of the hidden cipher key store. It ties the register front end, the slot
// storage and the cipher-side lookup together. Assumes synchronous active-low reset.
module cipher_key_vault
    import ckv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              fuse_key_stb,
    input  logic [KEY_W-1:0]  fuse_key,
    input  logic [SEL_W-1:0]  key_sel,
    output logic [KEY_W-1:0]  key_out
);
    logic                             kw_en;
    logic [SEL_W-1:0]                 kw_slot;
    logic [PTR_W-1:0]                 kw_word;
    logic [WORD_W-1:0]                kw_data;
    logic [SEL_W-1:0]                 cur_slot;
    logic [PTR_W-1:0]                 cur_ptr;
    logic [ALL_SLOTS-1:0][KEY_W-1:0]  slot_keys;
    logic [ALL_SLOTS-1:0]             valid_flags;
    logic                             fuse_taken;

    ckv_regif u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .rd_en       (reg_rd_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .valid_flags (valid_flags),
        .rdata       (reg_rdata),
        .kw_en       (kw_en),
        .kw_slot     (kw_slot),
        .kw_word     (kw_word),
        .kw_data     (kw_data),
        .cur_slot    (cur_slot),
        .cur_ptr     (cur_ptr)
    );

    ckv_slot_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .kw_en      (kw_en),
        .kw_slot    (kw_slot),
        .kw_word    (kw_word),
        .kw_data    (kw_data),
        .fuse_stb   (fuse_key_stb),
        .fuse_key   (fuse_key),
        .slot_keys  (slot_keys),
        .slot_valid (valid_flags),
        .fuse_taken (fuse_taken)
    );

    ckv_read_port u_rport (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_sel    (key_sel),
        .slot_keys  (slot_keys),
        .slot_valid (valid_flags),
        .key_out    (key_out)
    );
endmodule

// File: rtl/ckv_checker.sv
// Property checker for the hidden cipher key store, attached to the top by bind.
module ckv_checker
    import ckv_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_wr_en,
    input logic                            reg_rd_en,
    input logic [1:0]                      reg_addr,
    input logic [WORD_W-1:0]               reg_rdata,
    input logic [SEL_W-1:0]                key_sel,
    input logic [KEY_W-1:0]                key_out,
    input logic [SEL_W-1:0]                cur_slot,
    input logic [PTR_W-1:0]                cur_ptr,
    input logic [ALL_SLOTS-1:0][KEY_W-1:0] slot_keys,
    input logic [ALL_SLOTS-1:0]            valid_flags,
    input logic                            fuse_taken
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && key_out == '0 && valid_flags == '0 && cur_ptr == '0));

    assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == REG_DATA) |=> (cur_ptr == $past(cur_ptr) + PTR_W'(1)));

    assert_data_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == REG_DATA) |=> (reg_rdata == '0));

    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((valid_flags & $past(valid_flags)) == $past(valid_flags)));

    assert_hidden_slot_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == REG_DATA && cur_slot >= SEL_W'(SW_SLOTS)) |=> $stable(slot_keys));

    assert_fuse_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_taken |=> (fuse_taken && $stable(slot_keys[FUSE_SLOT])));

    assert_bad_sel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_sel > SEL_W'(FUSE_SLOT)) |=> (key_out == '0));
endmodule

bind cipher_key_vault ckv_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .key_sel     (key_sel),
    .key_out     (key_out),
    .cur_slot    (cur_slot),
    .cur_ptr     (cur_ptr),
    .slot_keys   (slot_keys),
    .valid_flags (valid_flags),
    .fuse_taken  (fuse_taken)
);

// File: tb/cipher_key_vault_tb_top.sv
`timescale 1ns/1ps
module cipher_key_vault_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic         reg_rd_en = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         fuse_key_stb = 1'b0;
    logic [127:0] fuse_key = '0;
    logic [2:0]   key_sel = 3'd0;
    logic [127:0] key_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model
    logic [127:0] m_key [5];
    logic [4:0]   m_val;
    logic [2:0]   m_idx;
    logic [1:0]   m_ptr;
    bit           m_fuse_done;

    always #2 clk = ~clk;

    cipher_key_vault dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_rd_en    (reg_rd_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .fuse_key_stb (fuse_key_stb),
        .fuse_key     (fuse_key),
        .key_sel      (key_sel),
        .key_out      (key_out)
    );

    function automatic logic [127:0] exp_key(input logic [2:0] sel);
        if (sel <= 3'd4 && m_val[sel]) return m_key[sel];
        return '0;
    endfunction

    function automatic logic [31:0] exp_select();
        logic [31:0] v = '0;
        v[2:0] = m_idx;
        v[9:8] = m_ptr;
        return v;
    endfunction

    function automatic logic [31:0] exp_status();
        return {27'd0, m_val};
    endfunction

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) m_key[i] = '0;
        m_val = '0; m_idx = '0; m_ptr = '0; m_fuse_done = 1'b0;
    endtask

    task automatic wr_select(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_idx = d[2:0]; m_ptr = d[9:8];
    endtask

    task automatic wr_data(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (m_idx < 3'd4) begin
            m_key[m_idx][m_ptr*32 +: 32] = d;
            if (m_ptr == 2'd3) m_val[m_idx] = 1'b1;
        end
        m_ptr = m_ptr + 2'd1;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        chk32(req, reg_rdata, exp);
    endtask

    task automatic key_check(input string req, input logic [2:0] sel);
        @(negedge clk);
        key_sel = sel;
        @(negedge clk);
        chk128(req, key_out, exp_key(sel));
    endtask

    task automatic fuse_pulse(input logic [127:0] k);
        @(negedge clk);
        fuse_key_stb = 1'b1; fuse_key = k;
        @(negedge clk);
        fuse_key_stb = 1'b0;
        if (!m_fuse_done) begin
            m_key[4] = k; m_val[4] = 1'b1; m_fuse_done = 1'b1;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [127:0] k1;
        logic [127:0] k2;
        void'($urandom(32'h5eed_c0de));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check("R1 status after reset", 2'd2, 32'd0);
        rd_check("R1 select after reset", 2'd0, 32'd0);
        for (int s = 0; s < 8; s++) key_check("R1 R8 key after reset", 3'(s));

        // R2: select register write and readback, extra bits ignored
        wr_select(32'hFFFF_FC_F9 & 32'hFFFF_FDF9);
        rd_check("R2 select readback", 2'd0, exp_select());

        // R3 R5 R8: fill slot 2, partial key hidden, full key visible
        wr_select(32'h0000_0002);
        wr_data(32'h1111_0000); wr_data(32'h2222_0001); wr_data(32'h3333_0002);
        rd_check("R5 flag clear before last word", 2'd2, exp_status());
        key_check("R8 partial slot reads zero", 3'd2);
        wr_data(32'h4444_0003);
        rd_check("R5 flag set after last word", 2'd2, exp_status());
        key_check("R3 slot 2 contents", 3'd2);
        rd_check("R3 pointer wrapped to 0", 2'd0, exp_select());

        // R4: hidden readback
        rd_check("R4 data register reads zero", 2'd1, 32'd0);
        rd_check("R4 spare address reads zero", 2'd3, 32'd0);

        // R6: writes to fuse slot index before capture
        wr_select(32'h0000_0004);
        for (int w = 0; w < 4; w++) wr_data($urandom);
        rd_check("R6 fuse flag untouched by writes", 2'd2, exp_status());
        key_check("R6 fuse slot still empty", 3'd4);
        rd_check("R6 pointer still advances", 2'd0, exp_select());

        // R7: fuse capture once
        k1 = {$urandom, $urandom, $urandom, $urandom};
        k2 = ~k1;
        fuse_pulse(k1);
        key_check("R7 fuse key captured", 3'd4);
        rd_check("R7 fuse flag set", 2'd2, exp_status());
        fuse_pulse(k2);
        key_check("R7 second strobe ignored", 3'd4);
        wr_select(32'h0000_0004);
        wr_data(32'hDEAD_BEEF);
        key_check("R6 software write to fuse slot ignored", 3'd4);
        wr_select(32'h0000_0007);
        wr_data(32'hCAFE_F00D);
        key_check("R6 write to slot 7 changes nothing", 3'd2);
        key_check("R8 invalid slot 7 reads zero", 3'd7);

        // R3: start mid-key and wrap
        wr_select(32'h0000_0201);
        wr_data(32'hA0A0_0002); wr_data(32'hA0A0_0003);
        rd_check("R3 wrap mid-key", 2'd0, exp_select());
        wr_data(32'hA0A0_0000); wr_data(32'hA0A0_0001);
        key_check("R3 R5 slot 1 after wrapped fill", 3'd1);

        // Random mix
        for (int n = 0; n < 500; n++) begin
            int op = $urandom % 10;
            if (op < 2) begin
                wr_select($urandom & 32'h0000_03FF);
            end else if (op < 6) begin
                wr_data($urandom);
            end else if (op < 8) begin
                key_check("R8 random key lookup", 3'($urandom % 8));
            end else if (op == 8) begin
                rd_check("R5 random status", 2'd2, exp_status());
            end else begin
                logic [1:0] a = 2'($urandom % 4);
                if (a == 2'd0) rd_check("R2 random select", a, exp_select());
                else if (a == 2'd2) rd_check("R5 random status", a, exp_status());
                else rd_check("R4 random hidden read", a, 32'd0);
            end
        end
        for (int s = 0; s < 8; s++) key_check("R8 final sweep", 3'(s));

        done = 1'b1;
        summary();
    end
endmodule